// File: doc/BRIEF.md
# Conflict-Free Ray Job Dispatcher

This block walks through every (view, detector row, detector column) triple of a projection set and hands each one, as a ray job, to one of several parallel tracer lanes. Lanes are served in rotating order. A lane that is not ready is skipped. Each lane returns a one-cycle acknowledge when its ray is finished. The acknowledge is raised whether or not the ray hit the volume.

In backward mode, rays that run at the same time must never write the same voxel. The dispatcher meets this without atomic memory updates. Within a view, the detectors are split into groups by their offset modulo a fixed stride in each axis, so every member of a group is at least one stride from every other. A group may start only once every ray issued before it has been acknowledged. The first group of a view is also a group start, so views run strictly one after another. In forward mode no barrier applies and jobs stream out as fast as lanes accept them.

A completion tally counts acknowledges and raises a one-cycle done pulse once the whole set has been retired. The tally also keeps the number of rays still in flight, and the backward barrier uses it.

Top module: `ray_dispatch`

## Requirements
- R1: After reset, and with no start, the block is idle: `busy_o` is 0, `done_o` is 0, and no bit of `lane_valid_o` is set, whatever the lane ready inputs are.
- R2: Jobs are issued in this order:
  - view is the outermost loop, ascending;
  - inside a view come the row offset, 0 to min(STRIDE,N_ROWS)-1;
  - then the column offset, 0 to min(STRIDE,N_COLS)-1;
  - then the row, from its offset upward in steps of STRIDE;
  - then the column, from its offset upward in steps of STRIDE.

  The same order is used in both modes. Each of the N_VIEWS·N_ROWS·N_COLS triples is issued exactly once.
- R3: In backward mode (`backward_i`=1 at start), a job whose row is below STRIDE and whose column is below STRIDE is the first job of a group. Such a job is issued only when every previously issued job has already been acknowledged.
- R4: In forward mode, jobs are never held back for outstanding rays. With all lanes ready and free, one job is issued every cycle from the first issue to the last.
- R5: A grant goes to the first ready lane found by scanning upward, with wraparound, from the lane after the last granted one. After reset, the scan starts at lane 0.
- R6: In any cycle at most one bit of `lane_valid_o` is set, and only for a lane whose ready input is 1. A set bit means that lane has taken the job on the job outputs in that cycle.
- R7: Every acknowledge bit counts as one retired ray, whether the ray hit or missed. Several lanes may acknowledge in the same cycle.
- R8: `done_o` is high for exactly one cycle, in the cycle after the acknowledge that retires the last ray. `busy_o` falls in the cycle after that.
- R9: A start pulse while `busy_o` is 1 is ignored. The job sequence, the mode and the count continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new projection set (honoured only when idle) |
| backward_i | input | 1 | Mode captured at start: 1 = backward (barriered), 0 = forward |
| lane_ready_i | input | N_LANES | Per-lane ready to accept a job |
| lane_ack_i | input | N_LANES | Per-lane completion strobe, raised for hits and misses alike |
| lane_valid_o | output | N_LANES | One-hot job handoff to the granted lane |
| job_view_o | output | idx_w(N_VIEWS) | View index of the offered job |
| job_row_o | output | idx_w(N_ROWS) | Detector row of the offered job |
| job_col_o | output | idx_w(N_COLS) | Detector column of the offered job |
| busy_o | output | 1 | A projection set is in progress |
| done_o | output | 1 | One-cycle pulse when all rays are retired |

## Verification
The issue of a new job and the retirement of older ones often share a cycle, and the in-flight count must add and subtract in that same cycle. The backward barrier and the done pulse both rely on that count. The bench provokes this by giving every lane the same latency, and by using sparse ready masks, so that grants and acknowledges from several lanes pile into the same cycles. It judges the outcome in three ways:
- no backward group start appears while the bench's own in-flight count is nonzero;
- the done pulse lands exactly one cycle after the final acknowledge;
- every job matches the expected order and lane.

// File: rtl/ray_dispatch_pkg.sv
package ray_dispatch_pkg;

  typedef enum logic {
    MODE_FWD = 1'b0,
    MODE_BWD = 1'b1
  } trace_mode_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ray_seq_gen.sv
module ray_seq_gen
  import ray_dispatch_pkg::*;
#(
  parameter int N_VIEWS = 36,
  parameter int N_ROWS  = 64,
  parameter int N_COLS  = 64,
  parameter int STRIDE  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      adv_i,
  output logic                      valid_o,
  output logic                      first_o,
  output logic [idx_w(N_VIEWS)-1:0] view_o,
  output logic [idx_w(N_ROWS)-1:0]  row_o,
  output logic [idx_w(N_COLS)-1:0]  col_o
);

  localparam int VW = idx_w(N_VIEWS);
  localparam int RW = idx_w(N_ROWS);
  localparam int CW = idx_w(N_COLS);
  localparam int RG = min_i(STRIDE, N_ROWS);
  localparam int CG = min_i(STRIDE, N_COLS);

  logic [VW-1:0] view_q, view_d;
  logic [RW-1:0] roff_q, roff_d, row_q, row_d;
  logic [CW-1:0] coff_q, coff_d, col_q, col_d;
  logic          valid_q, valid_d;

  always_comb begin
    view_d  = view_q;
    roff_d  = roff_q;
    coff_d  = coff_q;
    row_d   = row_q;
    col_d   = col_q;
    valid_d = valid_q;
    if (load_i) begin
      view_d  = '0;
      roff_d  = '0;
      coff_d  = '0;
      row_d   = '0;
      col_d   = '0;
      valid_d = 1'b1;
    end else if (adv_i && valid_q) begin
      if (int'(col_q) + STRIDE < N_COLS) begin
        col_d = CW'(int'(col_q) + STRIDE);
      end else if (int'(row_q) + STRIDE < N_ROWS) begin
        row_d = RW'(int'(row_q) + STRIDE);
        col_d = coff_q;
      end else if (int'(coff_q) + 1 < CG) begin
        coff_d = coff_q + 1'b1;
        row_d  = roff_q;
        col_d  = coff_q + 1'b1;
      end else if (int'(roff_q) + 1 < RG) begin
        roff_d = roff_q + 1'b1;
        coff_d = '0;
        row_d  = roff_q + 1'b1;
        col_d  = '0;
      end else if (int'(view_q) + 1 < N_VIEWS) begin
        view_d = view_q + 1'b1;
        roff_d = '0;
        coff_d = '0;
        row_d  = '0;
        col_d  = '0;
      end else begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      view_q  <= '0;
      roff_q  <= '0;
      coff_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      view_q  <= view_d;
      roff_q  <= roff_d;
      coff_q  <= coff_d;
      row_q   <= row_d;
      col_q   <= col_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign first_o = (row_q == roff_q) && (col_q == coff_q);
  assign view_o  = view_q;
  assign row_o   = row_q;
  assign col_o   = col_q;

  // offered job may only change when taken or reloaded
  p_hold_job_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !adv_i && !load_i |=> $stable({view_q, row_q, col_q}));

  p_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (int'(row_q) < N_ROWS) && (int'(col_q) < N_COLS) && (int'(view_q) < N_VIEWS));

endmodule

// File: rtl/lane_rr_arb.sv
module lane_rr_arb
  import ray_dispatch_pkg::*;
#(
  parameter int N_LANES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [N_LANES-1:0] ready_i,
  output logic [N_LANES-1:0] gnt_o
);

  localparam int LW = idx_w(N_LANES);

  logic [LW-1:0] last_q, last_d;

  always_comb begin
    logic found;
    int   idx;
    gnt_o  = '0;
    last_d = last_q;
    found  = 1'b0;
    for (int k = 1; k <= N_LANES; k++) begin
      idx = (int'(last_q) + k) % N_LANES;
      if (!found && req_i && ready_i[idx]) begin
        gnt_o[idx] = 1'b1;
        last_d     = LW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= LW'(N_LANES - 1);
    else         last_q <= last_d;
  end

  p_gnt_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~ready_i) == '0);

endmodule

// File: rtl/ray_tally.sv
module ray_tally
  import ray_dispatch_pkg::*;
#(
  parameter int TOTAL   = 147456,
  parameter int N_LANES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       issue_i,
  input  logic [N_LANES-1:0]         ack_i,
  output logic [idx_w(TOTAL+1)-1:0]  outst_o,
  output logic                       done_o
);

  localparam int TW = idx_w(TOTAL + 1);
  localparam int AW = idx_w(N_LANES + 1);

  logic [AW-1:0] ack_cnt;
  logic [TW-1:0] retired_q, retired_d, outst_q, outst_d;
  logic          done_q;

  always_comb begin
    ack_cnt = '0;
    for (int k = 0; k < N_LANES; k++) ack_cnt = ack_cnt + AW'(ack_i[k]);
  end

  always_comb begin
    if (clear_i) begin
      retired_d = '0;
      outst_d   = '0;
    end else begin
      retired_d = retired_q + TW'(ack_cnt);
      outst_d   = outst_q + TW'(issue_i) - TW'(ack_cnt);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retired_q <= '0;
      outst_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      retired_q <= retired_d;
      outst_q   <= outst_d;
      done_q    <= !clear_i && (retired_d == TW'(TOTAL)) && (retired_q != TW'(TOTAL));
    end
  end

  assign outst_o = outst_q;
  assign done_o  = done_q;

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    TW'(ack_cnt) <= outst_q);

  p_retired_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retired_q <= TW'(TOTAL));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/ray_dispatch.sv
module ray_dispatch
  import ray_dispatch_pkg::*;
#(
  parameter int N_VIEWS = 36,
  parameter int N_ROWS  = 64,
  parameter int N_COLS  = 64,
  parameter int STRIDE  = 5,
  parameter int N_LANES = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      backward_i,
  input  logic [N_LANES-1:0]        lane_ready_i,
  input  logic [N_LANES-1:0]        lane_ack_i,
  output logic [N_LANES-1:0]        lane_valid_o,
  output logic [idx_w(N_VIEWS)-1:0] job_view_o,
  output logic [idx_w(N_ROWS)-1:0]  job_row_o,
  output logic [idx_w(N_COLS)-1:0]  job_col_o,
  output logic                      busy_o,
  output logic                      done_o
);

  localparam int TOTAL = N_VIEWS * N_ROWS * N_COLS;
  localparam int TW    = idx_w(TOTAL + 1);

  trace_mode_e   mode_q;
  logic          busy_q;
  logic          load;
  logic          seq_valid, seq_first;
  logic          issue_ok, issue;
  logic [TW-1:0] outst;
  logic [N_LANES-1:0] gnt;

  assign load = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= MODE_FWD;
    end else if (load) begin
      busy_q <= 1'b1;
      mode_q <= backward_i ? MODE_BWD : MODE_FWD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  ray_seq_gen #(
    .N_VIEWS(N_VIEWS), .N_ROWS(N_ROWS), .N_COLS(N_COLS), .STRIDE(STRIDE)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (issue),
    .valid_o(seq_valid),
    .first_o(seq_first),
    .view_o (job_view_o),
    .row_o  (job_row_o),
    .col_o  (job_col_o)
  );

  // backward: a group opens only on an empty pipe
  assign issue_ok = seq_valid && ((mode_q == MODE_FWD) || !seq_first || (outst == '0));

  lane_rr_arb #(.N_LANES(N_LANES)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (issue_ok),
    .ready_i(lane_ready_i),
    .gnt_o  (gnt)
  );

  assign issue = |gnt;

  ray_tally #(.TOTAL(TOTAL), .N_LANES(N_LANES)) i_tally (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .issue_i(issue),
    .ack_i  (lane_ack_i),
    .outst_o(outst),
    .done_o (done_o)
  );

  assign lane_valid_o = gnt;
  assign busy_o       = busy_q;

  p_barrier_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BWD) && issue && seq_first |-> outst == '0);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> lane_valid_o == '0);

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(mode_q));

endmodule

// File: tb/test_ray_dispatch.sv
module test_ray_dispatch;

  localparam int V = 2;
  localparam int R = 6;
  localparam int C = 7;
  localparam int S = 5;
  localparam int L = 8;
  localparam int TOTAL = V * R * C;
  localparam int VW = 1;
  localparam int RW = 3;
  localparam int CW = 3;

  // {backward, ready mask, latency, start poke mid-run}
  localparam logic [13:0] SCEN [6] = '{
    {1'b0, 8'hFF, 4'd3, 1'b0},
    {1'b1, 8'hFF, 4'd2, 1'b0},
    {1'b1, 8'hA6, 4'd5, 1'b1},
    {1'b0, 8'h11, 4'd1, 1'b1},
    {1'b1, 8'h01, 4'd1, 1'b0},
    {1'b0, 8'h7E, 4'd0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          backward_i = 1'b0;
  logic [L-1:0]  lane_ready_i = '0;
  logic [L-1:0]  lane_ack_i = '0;
  logic [L-1:0]  lane_valid_o;
  logic [VW-1:0] job_view_o;
  logic [RW-1:0] job_row_o;
  logic [CW-1:0] job_col_o;
  logic          busy_o, done_o;

  ray_dispatch #(.N_VIEWS(V), .N_ROWS(R), .N_COLS(C), .STRIDE(S), .N_LANES(L)) i_ray_dispatch (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .backward_i(backward_i),
    .lane_ready_i(lane_ready_i), .lane_ack_i(lane_ack_i), .lane_valid_o(lane_valid_o),
    .job_view_o(job_view_o), .job_row_o(job_row_o), .job_col_o(job_col_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_v [TOTAL];
  int exp_r [TOTAL];
  int exp_c [TOTAL];
  logic [L-1:0] pend = '0;
  int tmr [L];
  logic [L-1:0] mask = '0;
  int lat = 0;
  logic bwd = 1'b0;
  int issued, retired, outst, last_gnt, cyc, done_cnt, last_ack_cyc, first_iss, last_iss;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic step();
    logic [L-1:0] acks;
    @(negedge clk);
    cyc++;
    acks = '0;
    for (int k = 0; k < L; k++) begin
      if (pend[k]) begin
        if (tmr[k] == 0) acks[k] = 1'b1;
        else tmr[k]--;
      end
    end
    lane_ready_i = mask & ~pend;
    lane_ack_i   = acks;
    #1;
    if (done_o) begin
      done_cnt++;
      check(cyc == last_ack_cyc + 1 && retired == TOTAL, "R8 done timing", cyc, last_ack_cyc + 1);
    end
    if (lane_valid_o != '0) begin
      int k;
      int e;
      k = 0;
      e = -1;
      for (int j = 0; j < L; j++) if (lane_valid_o[j]) k = j;
      check($onehot(lane_valid_o) && ((lane_valid_o & ~lane_ready_i) == '0), "R6 grant",
            int'(lane_valid_o), int'(lane_ready_i));
      for (int j = 1; j <= L; j++) begin
        int idx;
        idx = (last_gnt + j) % L;
        if (e < 0 && lane_ready_i[idx]) e = idx;
      end
      check(k == e, "R5 lane", k, e);
      if (issued < TOTAL) begin
        check(int'(job_view_o) == exp_v[issued] && int'(job_row_o) == exp_r[issued] &&
              int'(job_col_o) == exp_c[issued], "R2 job",
              int'(job_view_o) * 100 + int'(job_row_o) * 10 + int'(job_col_o),
              exp_v[issued] * 100 + exp_r[issued] * 10 + exp_c[issued]);
      end else begin
        check(1'b0, "R2 extra job", issued, TOTAL - 1);
      end
      if (bwd && int'(job_row_o) < S && int'(job_col_o) < S)
        check(outst == 0, "R3 group start with rays in flight", outst, 0);
      if (issued == 0) first_iss = cyc;
      last_iss = cyc;
      pend[k] = 1'b1;
      tmr[k]  = lat;
      issued++;
      outst++;
      last_gnt = k;
    end
    for (int k = 0; k < L; k++) begin
      if (acks[k]) begin
        pend[k] = 1'b0;
        retired++;
        outst--;
        last_ack_cyc = cyc;
      end
    end
  endtask

  task automatic run(input logic [13:0] sc);
    int guard;
    bwd  = sc[13];
    mask = sc[12:5];
    lat  = int'(sc[4:1]);
    issued = 0; retired = 0; outst = 0; done_cnt = 0; last_ack_cyc = -10;
    first_iss = 0; last_iss = 0;
    backward_i = bwd;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin
      guard++;
      if (sc[0] && guard == 12) begin
        start_i = 1'b1;  // R9: must be ignored
        backward_i = ~bwd;
      end
      step();
      start_i = 1'b0;
      backward_i = bwd;
    end
    if (guard >= 20000) check(1'b0, "R8 run timeout", guard, 0);
    for (int n = 0; n < 4; n++) step();
    check(issued == TOTAL, "R2 issued count", issued, TOTAL);
    check(retired == TOTAL, "R7 retired count", retired, TOTAL);
    check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    check(busy_o == 1'b0, "R8 busy after done", int'(busy_o), 0);
    check(lane_valid_o == '0, "R9 no jobs after done", int'(lane_valid_o), 0);
    if (!bwd && mask == '1)
      check(last_iss - first_iss == TOTAL - 1, "R4 back-to-back", last_iss - first_iss, TOTAL - 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    for (int v = 0; v < V; v++)
      for (int ro = 0; ro < ((S < R) ? S : R); ro++)
        for (int co = 0; co < ((S < C) ? S : C); co++)
          for (int r = ro; r < R; r += S)
            for (int c = co; c < C; c += S) begin
              exp_v[n] = v; exp_r[n] = r; exp_c[n] = c; n++;
            end
    for (int k = 0; k < L; k++) tmr[k] = 0;
    cyc = 0;
    last_gnt = L - 1;
    #20;
    rst_ni = 1'b1;
    // R1: idle after reset, lanes ready, no start
    mask = '1;
    for (int k = 0; k < 3; k++) begin
      step();
      check(lane_valid_o == '0 && !busy_o && !done_o, "R1 idle after reset",
            int'(lane_valid_o) + int'(busy_o) + int'(done_o), 0);
    end
    for (int s = 0; s < 6; s++) run(SCEN[s]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule